// File: doc/BRIEF.md
# Capture, Compare and PWM Timer Channel

This block is one channel of a timer peripheral. It holds one 16-bit data register, and a 4-bit mode code decides what that register does. In capture modes the register records the value of an external free-running 16-bit timer when the input pin shows a selected edge. Edges can be taken one at a time or counted in groups of four or sixteen. In compare modes the register is the match target: when the timer first equals it, the channel toggles, sets or clears its pin, raises only the interrupt flag, or pulses a special-event strobe that other logic can use to reset the timer and start a conversion. In PWM modes the low byte of the register and two bits of the control register form a 10-bit duty value. The channel compares that value against an 8-bit external timebase that it extends internally with two sub-count bits.

Software reaches the channel through a small byte-wide register port with four addresses:
- Address 0 is the control register. Bits 3:0 hold the mode and bits 5:4 hold the two low duty bits.
- Addresses 1 and 2 hold the low and high bytes of the data register.
- Address 3 holds the interrupt flag in bit 0. Writing a one to that bit clears the flag.

Reads are combinational from the same address lines. A write of a new mode code counts as entry into that mode. The data register keeps its contents across mode changes.

Top module: `capture_compare_pwm`

## Requirements
- R1: After reset every register reads 0 and pinOut, pinDrive, intFlag and specialEvent are low. Entering mode 0000 clears the capture edge counter and the output latch, and raises no flag.
- R2: Mode codes 0001 and 0011 act as disabled: no capture, no flag, no special event, the data register is unchanged, and pinDrive and pinOut stay low.
- R3: The pin passes through a two-flop synchroniser. Mode 0101 captures timerVal on each rising edge and mode 0100 captures it on each falling edge. The opposite edge is ignored. Each capture sets intFlag.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. No capture happens on the edges in between.
- R5: Any change of mode code clears the capture edge counter, so a count started in one mode never completes in another.
- R6: Mode 0010 drives the pin (pinDrive=1). The pin starts low on entry and toggles at each compare match, and every match sets intFlag.
- R7: Mode 1000 drives the pin low on entry and high at a match. Mode 1001 drives it high on entry and low at a match. Both set intFlag at the match.
- R8: Mode 1010 sets intFlag at a match. pinDrive and pinOut stay low in this mode.
- R9: Mode 1011 sets intFlag at a match and raises specialEvent for exactly one cycle. The pin is not driven.
- R10: A match is the first cycle in which timerVal equals the data register. A timer held at the matching value produces no further match.
- R11: Writing 1 to bit 0 of address 3 clears intFlag. Writing 0 has no effect, and a new event in the same cycle wins over the clear. Address 0 reads back {2'b00, duty low bits, mode}.
- R12: Any mode 11xx selects PWM and drives the pin. The duty value is {data[7:0], control[5:4]}. The cycle at offset n after a period strobe has extended timebase n, and the pin is high after that cycle exactly when n < duty. A duty of 0 keeps the pin low.
- R13: A duty write takes effect only at the next period strobe. A duty at or beyond the period length keeps the pin high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| timerVal | input | 16 | Free-running timer value |
| pwmBase | input | 8 | PWM period timebase, upper 8 bits of the duty comparison |
| periodStrobe | input | 1 | Period restart strobe of the PWM timebase |
| pinIn | input | 1 | Asynchronous pin input |
| pinOut | output | 1 | Pin output level, low when not driven |
| pinDrive | output | 1 | High when the channel owns the pin |
| intFlag | output | 1 | Sticky interrupt flag |
| specialEvent | output | 1 | One-cycle timer-reset / conversion-start request |

## Verification
The bench targets four weak spots:
- Prescaled capture after a mode change. Counting through the switch without clearing the counter would fire at the 14th edge of a divide-by-16 mode instead of the 16th.
- A timer that stalls on the matching value. Retriggering would toggle the pin four times, so its final level comes out wrong, and would give four special-event pulses instead of one.
- The double-buffered duty. Loading it straight from the register would cut the period that is running short.
- The duty boundaries: zero, the period length and full scale. An off-by-one comparison shows there as one extra or one missing high cycle.

Reserved codes are exercised with both edges and matches, to catch a decoder that folds them into a neighbouring mode.

// File: rtl/ccp_unit_pkg.sv
package ccp_unit_pkg;
  localparam int BYTE_W    = 8;
  localparam int DATA_W    = 2 * BYTE_W;
  localparam int MODE_W    = 4;
  localparam int DUTY_LO_W = 2;
  localparam int DUTY_W    = BYTE_W + DUTY_LO_W;
  localparam int ADDR_W    = 2;
  localparam int CNT_W     = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  localparam logic [MODE_W-1:0] MODE_OFF        = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOGGLE     = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_CAP_FALL   = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_CAP_RISE   = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_CAP_RISE4  = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_CAP_RISE16 = 4'b0111;
  localparam logic [MODE_W-1:0] MODE_FORCE_HIGH = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_FORCE_LOW  = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_FLAG_ONLY  = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_SPECIAL    = 4'b1011;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_TOGGLE, ACT_HIGH, ACT_LOW, ACT_FLAG, ACT_SPECIAL
  } cmpAct_e;

  typedef enum logic [1:0] {SCALE_1, SCALE_4, SCALE_16} capScale_e;

  typedef struct packed {
    logic                 capEn;
    logic                 capFalling;
    capScale_e            capScale;
    logic                 cmpEn;
    cmpAct_e              cmpAct;
    logic                 pwmEn;
    logic                 driveEn;
    logic                 modeEntry;
    logic                 entryLevel;
    logic                 wrDataLo;
    logic                 wrDataHi;
    logic [BYTE_W-1:0]    wrByte;
    logic [DUTY_LO_W-1:0] dutyLo;
  } ctrlStrobe_t;
endpackage

// File: rtl/ccp_unit_ctrl.sv
module ccp_unit_ctrl
  import ccp_unit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [BYTE_W-1:0]    regWrData,
  input  logic                 hitEvent,
  output ctrlStrobe_t          strobe,
  output logic [MODE_W-1:0]    modeQ,
  output logic [DUTY_LO_W-1:0] dutyLoQ,
  output logic                 flagQ
);
  logic              wrCtrl;
  logic              wrStat;
  logic [MODE_W-1:0] newMode;

  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat  = regWrEn && (regAddr == ADDR_STAT);
  assign newMode = regWrData[MODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_OFF;
      dutyLoQ <= '0;
      flagQ   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        modeQ   <= newMode;
        dutyLoQ <= regWrData[MODE_W +: DUTY_LO_W];
      end
      // an event in the same cycle beats the software clear
      if (hitEvent)                  flagQ <= 1'b1;
      else if (wrStat && regWrData[0]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.capEn      = 1'b0;
    strobe.capFalling = 1'b0;
    strobe.capScale   = SCALE_1;
    strobe.cmpEn      = 1'b0;
    strobe.cmpAct     = ACT_NONE;
    strobe.pwmEn      = 1'b0;
    strobe.driveEn    = 1'b0;
    casez (modeQ)
      MODE_TOGGLE:     begin strobe.cmpEn = 1'b1; strobe.cmpAct = ACT_TOGGLE; strobe.driveEn = 1'b1; end
      MODE_CAP_FALL:   begin strobe.capEn = 1'b1; strobe.capFalling = 1'b1; end
      MODE_CAP_RISE:   strobe.capEn = 1'b1;
      MODE_CAP_RISE4:  begin strobe.capEn = 1'b1; strobe.capScale = SCALE_4; end
      MODE_CAP_RISE16: begin strobe.capEn = 1'b1; strobe.capScale = SCALE_16; end
      MODE_FORCE_HIGH: begin strobe.cmpEn = 1'b1; strobe.cmpAct = ACT_HIGH; strobe.driveEn = 1'b1; end
      MODE_FORCE_LOW:  begin strobe.cmpEn = 1'b1; strobe.cmpAct = ACT_LOW;  strobe.driveEn = 1'b1; end
      MODE_FLAG_ONLY:  begin strobe.cmpEn = 1'b1; strobe.cmpAct = ACT_FLAG; end
      MODE_SPECIAL:    begin strobe.cmpEn = 1'b1; strobe.cmpAct = ACT_SPECIAL; end
      4'b11??:         begin strobe.pwmEn = 1'b1; strobe.driveEn = 1'b1; end
      default:         ; // off and reserved codes
    endcase
    strobe.modeEntry  = wrCtrl && (newMode != modeQ);
    strobe.entryLevel = (newMode == MODE_FORCE_LOW);
    strobe.wrDataLo   = regWrEn && (regAddr == ADDR_LO);
    strobe.wrDataHi   = regWrEn && (regAddr == ADDR_HI);
    strobe.wrByte     = regWrData;
    strobe.dutyLo     = dutyLoQ;
  end
endmodule

// File: rtl/ccp_unit_datapath.sv
module ccp_unit_datapath
  import ccp_unit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] timerVal,
  input  logic [BYTE_W-1:0] pwmBase,
  input  logic              periodStrobe,
  input  logic              pinIn,
  output logic [DATA_W-1:0] dataQ,
  output logic              pinLevel,
  output logic              specialEvent,
  output logic              hitEvent
);
  localparam logic [CNT_W-1:0] LIMIT_4  = CNT_W'(3);
  localparam logic [CNT_W-1:0] LIMIT_16 = CNT_W'(15);

  // input synchroniser and edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSync, pinPrev, riseSeen, fallSeen, edgeSeen;

  assign pinSync  = syncQ[SYNC_STAGES-1];
  assign riseSeen = pinSync && !pinPrev;
  assign fallSeen = !pinSync && pinPrev;
  assign edgeSeen = strobe.capEn && (strobe.capFalling ? fallSeen : riseSeen);

  // capture prescaler
  logic [CNT_W-1:0] edgeCnt, edgeLimit;
  logic capHit;

  always_comb begin
    case (strobe.capScale)
      SCALE_4:  edgeLimit = LIMIT_4;
      SCALE_16: edgeLimit = LIMIT_16;
      default:  edgeLimit = '0;
    endcase
  end
  assign capHit = edgeSeen && (edgeCnt == edgeLimit);

  // compare: only the first cycle of equality counts
  logic eqNow, eqPrev, cmpHit;
  assign eqNow    = (timerVal == dataQ);
  assign cmpHit   = strobe.cmpEn && eqNow && !eqPrev;
  assign hitEvent = capHit || cmpHit;

  // PWM: 8-bit external base extended by an internal sub-count
  logic [DUTY_LO_W-1:0] subQ;
  logic [DUTY_W-1:0]    dutyActive, dutyNext, extBase;
  assign dutyNext = {dataQ[BYTE_W-1:0], strobe.dutyLo};
  assign extBase  = {pwmBase, subQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
      eqPrev  <= 1'b0;
      edgeCnt <= '0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinIn};
      pinPrev <= pinSync;
      eqPrev  <= eqNow;
      if (strobe.modeEntry || !strobe.capEn) edgeCnt <= '0;
      else if (edgeSeen)                     edgeCnt <= capHit ? '0 : edgeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (capHit) begin
      dataQ <= timerVal;
    end else begin
      if (strobe.wrDataLo) dataQ[BYTE_W-1:0]      <= strobe.wrByte;
      if (strobe.wrDataHi) dataQ[DATA_W-1:BYTE_W] <= strobe.wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subQ       <= '0;
      dutyActive <= '0;
    end else begin
      subQ <= periodStrobe ? DUTY_LO_W'(1) : subQ + 1'b1;
      if (strobe.modeEntry)                       dutyActive <= '0;
      else if (strobe.pwmEn && periodStrobe)      dutyActive <= dutyNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinLevel     <= 1'b0;
      specialEvent <= 1'b0;
    end else begin
      specialEvent <= cmpHit && (strobe.cmpAct == ACT_SPECIAL);
      if (strobe.modeEntry) begin
        pinLevel <= strobe.entryLevel;
      end else if (strobe.pwmEn) begin
        if (periodStrobe)                 pinLevel <= (dutyNext != '0);
        else if (extBase == dutyActive)   pinLevel <= 1'b0;
      end else if (cmpHit) begin
        case (strobe.cmpAct)
          ACT_TOGGLE: pinLevel <= !pinLevel;
          ACT_HIGH:   pinLevel <= 1'b1;
          ACT_LOW:    pinLevel <= 1'b0;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/capture_compare_pwm.sv
module capture_compare_pwm
  import ccp_unit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [15:0]       timerVal,
  input  logic [7:0]        pwmBase,
  input  logic              periodStrobe,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinDrive,
  output logic              intFlag,
  output logic              specialEvent
);
  ctrlStrobe_t          strobe;
  logic [MODE_W-1:0]    modeQ;
  logic [DUTY_LO_W-1:0] dutyLoQ;
  logic                 flagQ;
  logic [DATA_W-1:0]    dataReg;
  logic                 pinLevel;
  logic                 hitEvent;

  ccp_unit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .hitEvent(hitEvent), .strobe(strobe),
    .modeQ(modeQ), .dutyLoQ(dutyLoQ), .flagQ(flagQ)
  );

  ccp_unit_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timerVal(timerVal),
    .pwmBase(pwmBase), .periodStrobe(periodStrobe), .pinIn(pinIn),
    .dataQ(dataReg), .pinLevel(pinLevel), .specialEvent(specialEvent),
    .hitEvent(hitEvent)
  );

  assign pinDrive = strobe.driveEn;
  assign pinOut   = strobe.driveEn && pinLevel;
  assign intFlag  = flagQ;

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = {{(BYTE_W-MODE_W-DUTY_LO_W){1'b0}}, dutyLoQ, modeQ};
      ADDR_LO:   regRdData = dataReg[BYTE_W-1:0];
      ADDR_HI:   regRdData = dataReg[DATA_W-1:BYTE_W];
      default:   regRdData = {{(BYTE_W-1){1'b0}}, flagQ};
    endcase
  end
endmodule

// File: rtl/capture_compare_pwm_chk.sv
module capture_compare_pwm_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  modeQ,
  input logic [15:0] dataReg,
  input logic [15:0] timerVal,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [7:0]  regWrData,
  input logic        pinOut,
  input logic        pinDrive,
  input logic        intFlag,
  input logic        specialEvent
);
  logic idleMode, reservedMode;
  assign reservedMode = (modeQ == 4'b0001) || (modeQ == 4'b0011);
  assign idleMode     = reservedMode || (modeQ == 4'b0000);

  assert_idle_no_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    idleMode |=> !$rose(intFlag));

  assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    reservedMode |-> (!pinOut && !pinDrive && !specialEvent));

  assert_toggle_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 4'b0010 && $past(modeQ) == 4'b0010 && pinOut != $past(pinOut))
      |-> $past(timerVal == dataReg));

  assert_flag_only_undriven_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 4'b1010) |-> (!pinDrive && !pinOut));

  assert_special_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    specialEvent |=> !specialEvent);

  assert_special_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(specialEvent) |-> ($past(modeQ) == 4'b1011));

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (idleMode && regWrEn && regAddr == 2'd3 && regWrData[0]) |=> !intFlag);

  assert_pwm_drive_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[3:2] == 2'b11) |-> pinDrive);
endmodule

bind capture_compare_pwm capture_compare_pwm_chk u_chk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ), .dataReg(dataReg),
  .timerVal(timerVal), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .pinOut(pinOut), .pinDrive(pinDrive),
  .intFlag(intFlag), .specialEvent(specialEvent)
);

// File: tb/capture_compare_pwm_bench.sv
module capture_compare_pwm_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [7:0]  regWrData = 8'd0;
  logic [7:0]  regRdData;
  logic [15:0] timerVal = 16'hFFFF;
  logic [7:0]  pwmBase = 8'd0;
  logic        periodStrobe = 1'b0;
  logic        pinIn = 1'b0;
  logic        pinOut, pinDrive, intFlag, specialEvent;

  int testsRun = 0;
  int testsFailed = 0;
  int eventCount = 0;
  bit finished = 1'b0;

  capture_compare_pwm u_capture_compare_pwm (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timerVal(timerVal),
    .pwmBase(pwmBase), .periodStrobe(periodStrobe), .pinIn(pinIn),
    .pinOut(pinOut), .pinDrive(pinDrive), .intFlag(intFlag),
    .specialEvent(specialEvent)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (rstN && specialEvent) eventCount++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic rdData(output logic [15:0] v);
    logic [7:0] lo, hi;
    rdReg(2'd1, lo);
    rdReg(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic setData(input logic [15:0] v);
    wrReg(2'd1, v[7:0]);
    wrReg(2'd2, v[15:8]);
  endtask

  task automatic clearFlag();
    wrReg(2'd3, 8'h01);
  endtask

  // rising half with timer riseVal, falling half with timer fallVal
  task automatic pulse(input logic [15:0] riseVal, input logic [15:0] fallVal);
    @(negedge clk); timerVal = riseVal; pinIn = 1'b1;
    repeat (4) @(negedge clk);
    timerVal = fallVal; pinIn = 1'b0;
    repeat (4) @(negedge clk);
    timerVal = 16'hFFFF;
  endtask

  // sweep timer across target, holding it there for 'stall' cycles
  task automatic matchSweep(input logic [15:0] target, input int stall);
    for (int o = -2; o <= 2; o++) begin
      @(negedge clk);
      timerVal = 16'(int'(target) + o);
      if (o == 0) repeat (stall - 1) @(negedge clk);
    end
    @(negedge clk); timerVal = 16'hFFFF;
    @(negedge clk);
  endtask

  task automatic prescaleRun(input string req, input int edges, input int div, input int base);
    logic [15:0] v, lastCap;
    rdData(lastCap);
    for (int e = 1; e <= edges; e++) begin
      v = 16'(base + e * 7);
      pulse(v, 16'hEEEE);
      chkEq(req, int'(intFlag), int'(e % div == 0));
      if (e % div == 0) begin
        lastCap = v;
        clearFlag();
      end
      rdData(v);
      chkEq(req, int'(v), int'(lastCap));
    end
  endtask

  // one 32-cycle PWM period: check curDuty, write nextDuty mid-period
  task automatic pwmPeriod(input int curDuty, input int nextDuty);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      if (n > 0) chkEq("R12/R13 pwm level", int'(pinOut), int'((n - 1) < curDuty));
      periodStrobe = (n == 0);
      pwmBase = 8'(n >> 2);
      regWrEn = 1'b0;
      if (n == 3) begin regWrEn = 1'b1; regAddr = 2'd1; regWrData = 8'(nextDuty >> 2); end
      if (n == 4) begin regWrEn = 1'b1; regAddr = 2'd0; regWrData = {2'b00, 2'(nextDuty), 4'b1100}; end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    periodStrobe = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    logic [15:0] v;
    int evBefore;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), r);
      chkEq("R1 reset register", int'(r), 0);
    end
    chkEq("R1 reset pins", int'({pinOut, pinDrive, intFlag, specialEvent}), 0);

    // R3 rising edge capture, falling ignored
    wrReg(2'd0, 8'h05);
    for (int i = 0; i < 8; i++) begin
      pulse(16'(16'h1000 + i * 16'h0111), 16'(16'h8000 + i));
      rdData(v);
      chkEq("R3 rising capture", int'(v), int'(16'h1000 + i * 16'h0111));
      chkEq("R3 rising flag", int'(intFlag), 1);
      wrReg(2'd3, 8'h00);
      chkEq("R11 write 0 keeps flag", int'(intFlag), 1);
      clearFlag();
      rdReg(2'd3, r);
      chkEq("R11 clear flag", int'(r), 0);
    end
    rdReg(2'd0, r);
    chkEq("R11 control readback", int'(r), 5);

    // R3 falling edge capture
    wrReg(2'd0, 8'h04);
    for (int i = 0; i < 6; i++) begin
      pulse(16'(16'h2000 + i), 16'(16'h3000 + i * 16'h0123));
      rdData(v);
      chkEq("R3 falling capture", int'(v), int'(16'h3000 + i * 16'h0123));
      chkEq("R3 falling flag", int'(intFlag), 1);
      clearFlag();
    end

    // R4 prescaled capture
    wrReg(2'd0, 8'h06);
    prescaleRun("R4 every 4th", 8, 4, 16'h0200);
    wrReg(2'd0, 8'h07);
    prescaleRun("R4 every 16th", 32, 16, 16'h0400);

    // R5 mode change clears edge counter
    wrReg(2'd0, 8'h06);
    pulse(16'h0900, 16'hEEEE);
    pulse(16'h0901, 16'hEEEE);
    wrReg(2'd0, 8'h07);
    prescaleRun("R5 counter cleared on mode change", 16, 16, 16'h0A00);

    // R1 mode 0000 clears the counter too
    wrReg(2'd0, 8'h06);
    pulse(16'h0B00, 16'hEEEE);
    pulse(16'h0B01, 16'hEEEE);
    wrReg(2'd0, 8'h00);
    chkEq("R1 disabled flag", int'(intFlag), 0);
    wrReg(2'd0, 8'h06);
    prescaleRun("R1 disable resets counter", 4, 4, 16'h0C00);

    // R2 reserved codes and off
    for (int m = 0; m < 3; m++) begin
      wrReg(2'd0, (m == 0) ? 8'h01 : (m == 1) ? 8'h03 : 8'h00);
      setData(16'h3333);
      pulse(16'h1111, 16'h2222);
      matchSweep(16'h3333, 2);
      rdData(v);
      chkEq("R2 reserved data kept", int'(v), 16'h3333);
      chkEq("R2 reserved quiet", int'({intFlag, pinOut, pinDrive}), 0);
    end

    // R6 toggle, R10 stall does not retrigger
    wrReg(2'd0, 8'h02);
    chkEq("R6 toggle entry low", int'({pinDrive, pinOut}), 2);
    for (int k = 0; k < 12; k++) begin
      setData(16'(k * 613 + 50));
      matchSweep(16'(k * 613 + 50), 4);
      chkEq("R6/R10 toggle level", int'(pinOut), (k + 1) % 2);
      chkEq("R6 toggle flag", int'(intFlag), 1);
      clearFlag();
    end

    // R7 force high / force low
    wrReg(2'd0, 8'h08);
    chkEq("R7 force-high entry", int'({pinDrive, pinOut}), 2);
    setData(16'h4321);
    matchSweep(16'h4321, 2);
    chkEq("R7 forced high", int'(pinOut), 1);
    chkEq("R7 flag", int'(intFlag), 1);
    clearFlag();
    matchSweep(16'h4321, 2);
    chkEq("R7 stays high", int'(pinOut), 1);
    wrReg(2'd0, 8'h09);
    chkEq("R7 force-low entry", int'({pinDrive, pinOut}), 3);
    matchSweep(16'h4321, 2);
    chkEq("R7 forced low", int'(pinOut), 0);
    chkEq("R7 flag low mode", int'(intFlag), 1);
    clearFlag();

    // R8 flag only
    wrReg(2'd0, 8'h0A);
    matchSweep(16'h4321, 3);
    chkEq("R8 flag only flag", int'(intFlag), 1);
    chkEq("R8 pin undriven", int'({pinDrive, pinOut}), 0);
    clearFlag();

    // R9 special event, R10 single pulse under stall
    wrReg(2'd0, 8'h0B);
    evBefore = eventCount;
    chkEq("R9 no event before match", int'(specialEvent), 0);
    matchSweep(16'h4321, 4);
    chkEq("R9/R10 one special pulse", eventCount - evBefore, 1);
    chkEq("R9 flag", int'(intFlag), 1);
    chkEq("R9 pin undriven", int'(pinDrive), 0);
    clearFlag();

    // R12/R13 PWM duty sweep, 32-cycle period
    wrReg(2'd0, 8'h00);
    setData(16'h0000);
    wrReg(2'd0, 8'h0C);
    chkEq("R12 pwm drives pin", int'(pinDrive), 1);
    for (int d = 0; d <= 40; d++) pwmPeriod(d, d + 1);
    pwmPeriod(41, 1023);
    pwmPeriod(1023, 0);
    pwmPeriod(0, 7);
    pwmPeriod(7, 7);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule